// File: doc/BRIEF.md
# Split-Transfer Serial Converter Reader

This block is the host side of a link to a 12-bit successive-approximation converter whose result register is shifted out by a serial clock that the host drives. The block starts conversions at a programmed spacing by pulsing an active-low convert line. It watches the converter's busy line for its rising edge, which marks the end of a conversion. It then collects the result over the serial data line.

The read of each result is split into two bursts. The first `FIRST_BITS` bits are clocked in right after busy rises. The remaining bits are clocked in just after the next convert pulse. That second burst stays well inside the early part of the new conversion, so no host-driven edge lands in the converter's noise-sensitive window or in the stretch just before busy rises.

The joined word is presented as a signed value with a one-cycle strobe. It is tagged with the index of the conversion that produced it, which is the conversion before the one in progress. If busy does not rise in time after a convert pulse, the block raises an error flag and drops the half-read word.

Top module: `adc_split_reader`

## Requirements
- R1: While rst_ni is low and after its release with en_i low, conv_n_o and cs_n_o are 1, sclk_o is 0, and rd_valid_o and err_o are 0.
- R2: Each convert pulse holds conv_n_o low for exactly CONV_LOW_CYC cycles. While en_i stays high, successive falling edges of conv_n_o are exactly period_i cycles apart.
- R3: No rising edge of sclk_o occurs earlier than SCLK_GAP_CYC cycles after conv_n_o falls.
- R4: sclk_o is high only while cs_n_o is low. At every busy_i rising edge, sclk_o is low and has been low for at least 2 µs.
- R5: After each busy_i rising edge, exactly FIRST_BITS sclk_o pulses follow before the next convert pulse. After that next convert pulse, exactly DATA_W-FIRST_BITS pulses follow before busy_i rises again, provided the previous conversion completed.
- R6: sdata_i is sampled at each falling edge of sclk_o. The first bit received becomes bit DATA_W-1 of rd_data_o. rd_data_o is a two's complement value (12'h800 reads as -2048). rd_valid_o is high for exactly one cycle, after the last bit of the second burst.
- R7: rd_tag_o carries the index, modulo 2^TAG_W, of the conversion that produced rd_data_o. The first conversion after reset has index 0, and every convert pulse advances the index, including pulses that time out.
- R8: No word is delivered during the first conversion after reset or during the first conversion after a timeout, because no first half is then pending.
- R9: If busy_i does not rise within TIMEOUT_CYC cycles of a convert pulse, err_o goes high, no serial clock follows, and the half word is dropped. err_o stays high until the next busy_i rising edge.
- R10: With en_i low, no new convert pulse is issued.
- R11: Each high phase and each low phase of sclk_o lasts div_i+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Allows new conversions to start |
| period_i | input | PER_W | Cycles between convert pulses |
| div_i | input | DIV_W | Serial clock half-phase length minus one, in cycles |
| conv_n_o | output | 1 | Active-low convert pulse |
| cs_n_o | output | 1 | Active-low chip select, low only during bursts |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_i | input | 1 | Converter busy line, low while converting |
| sdata_i | input | 1 | Serial result data, MSB first |
| rd_valid_o | output | 1 | One-cycle strobe for a finished word |
| rd_data_o | output | DATA_W | Signed result word |
| rd_tag_o | output | TAG_W | Index of the conversion the word belongs to |
| err_o | output | 1 | Busy timeout flag |

## Verification
The assertions assume that div_i stays constant while a burst runs. They also assume that period_i leaves room for the convert pulse, the busy wait and the first burst, and that busy_i rises only after the second burst has finished. The bench holds div_i and period_i fixed for the whole run. Its converter model lowers busy_i 40 ns after a convert edge and raises it 3.2 µs later. The second burst needs only about 0.65 µs, so busy_i never rises in the middle of a burst. The timeout case is produced by muting the model so that busy_i never falls.

// File: rtl/adc_split_pkg.sv
`timescale 1ns/1ps
package adc_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_GAP,
    ST_RD2,
    ST_WAITB,
    ST_RD1
  } rd_state_t;
endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/adc_sclk_burst.sv
`timescale 1ns/1ps
module adc_sclk_burst #(
  parameter int DIV_W = 8,
  parameter int BIT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIT_W-1:0] nbits_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             done_o
);
  logic             act_q, sclk_q;
  logic [DIV_W-1:0] hcnt_q;
  logic [BIT_W-1:0] bcnt_q;
  logic             turn;

  assign turn   = act_q && (hcnt_q == half_i);
  assign fall_o = turn && sclk_q;
  assign done_o = fall_o && (bcnt_q == nbits_i - BIT_W'(1));
  assign sclk_o = sclk_q;

  // each burst opens with a low half so data and select settle first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
    end else if (turn) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        bcnt_q <= bcnt_q + BIT_W'(1);
        if (done_o) act_q <= 1'b0;
      end
    end else if (act_q) begin
      hcnt_q <= hcnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/adc_split_reader.sv
`timescale 1ns/1ps
module adc_split_reader
  import adc_split_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int FIRST_BITS   = 8,
  parameter int PER_W        = 16,
  parameter int DIV_W        = 8,
  parameter int TAG_W        = 4,
  parameter int CONV_LOW_CYC = 13,
  parameter int SCLK_GAP_CYC = 16,
  parameter int TIMEOUT_CYC  = 3000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              conv_n_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              busy_i,
  input  logic              sdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              err_o
);
  localparam int SECOND_BITS = DATA_W - FIRST_BITS;
  localparam int BIT_W       = $clog2(DATA_W + 1);
  localparam int TO_W        = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W        = $clog2(SCLK_GAP_CYC + 1);

  rd_state_t         state_q;
  logic [PER_W-1:0]  per_q;
  logic [PH_W-1:0]   ph_q;
  logic [TO_W-1:0]   to_q;
  logic              pend_q, err_q, vld_q;
  logic [TAG_W-1:0]  tag_cnt_q, cur_tag_q, h_tag_q, rd_tag_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              busy_s, busy_q, busy_rise;
  logic              per_done, gap_end, burst_go;
  logic              smp, bdone;
  logic [BIT_W-1:0]  nbits;

  adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b1;
    else         busy_q <= busy_s;
  end

  assign busy_rise = busy_s && !busy_q;
  assign per_done  = ({1'b0, per_q} + (PER_W+1)'(1)) >= {1'b0, period_i};
  assign gap_end   = (state_q == ST_GAP) && (ph_q == PH_W'(SCLK_GAP_CYC - 1));
  assign burst_go  = (gap_end && pend_q) || ((state_q == ST_WAITB) && busy_rise);
  assign nbits     = (state_q == ST_RD2) ? BIT_W'(SECOND_BITS) : BIT_W'(FIRST_BITS);

  adc_sclk_burst #(.DIV_W(DIV_W), .BIT_W(BIT_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(burst_go),
    .nbits_i(nbits),
    .half_i (div_i),
    .sclk_o (sclk_o),
    .fall_o (smp),
    .done_o (bdone)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      per_q     <= '1;
      ph_q      <= '0;
      to_q      <= '0;
      pend_q    <= 1'b0;
      err_q     <= 1'b0;
      vld_q     <= 1'b0;
      tag_cnt_q <= '0;
      cur_tag_q <= '0;
      h_tag_q   <= '0;
      rd_tag_q  <= '0;
      sh_q      <= '0;
      data_q    <= '0;
    end else begin
      vld_q <= 1'b0;
      if (per_q != '1) per_q <= per_q + PER_W'(1);
      if (to_q != '1)  to_q  <= to_q + TO_W'(1);
      if (smp) sh_q <= {sh_q[DATA_W-2:0], sdata_i};
      unique case (state_q)
        ST_IDLE: if (en_i && per_done) begin
          state_q   <= ST_CONV;
          per_q     <= '0;
          ph_q      <= '0;
          to_q      <= '0;
          cur_tag_q <= tag_cnt_q;
          tag_cnt_q <= tag_cnt_q + TAG_W'(1);
        end
        ST_CONV: begin
          ph_q <= ph_q + PH_W'(1);
          if (ph_q == PH_W'(CONV_LOW_CYC - 1)) state_q <= ST_GAP;
        end
        ST_GAP: begin
          ph_q <= ph_q + PH_W'(1);
          if (gap_end) state_q <= pend_q ? ST_RD2 : ST_WAITB;
        end
        ST_RD2: if (bdone) begin
          vld_q    <= 1'b1;
          data_q   <= {sh_q[DATA_W-2:0], sdata_i};
          rd_tag_q <= h_tag_q;
          pend_q   <= 1'b0;
          state_q  <= ST_WAITB;
        end
        ST_WAITB: begin
          if (busy_rise) begin
            state_q <= ST_RD1;
            err_q   <= 1'b0;
            h_tag_q <= cur_tag_q;
          end else if (to_q >= TO_W'(TIMEOUT_CYC - 1)) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            pend_q  <= 1'b0;
          end
        end
        ST_RD1: if (bdone) begin
          pend_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_n_o   = (state_q != ST_CONV);
  assign cs_n_o     = !((state_q == ST_RD1) || (state_q == ST_RD2));
  assign rd_valid_o = vld_q;
  assign rd_data_o  = data_q;
  assign rd_tag_o   = rd_tag_q;
  assign err_o      = err_q;
endmodule

// File: rtl/adc_split_reader_chk.sv
`timescale 1ns/1ps
module adc_split_reader_chk #(
  parameter int DIV_W        = 8,
  parameter int CONV_LOW_CYC = 13,
  parameter int SCLK_GAP_CYC = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_i,
  input logic             conv_n_o,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             rd_valid_o,
  input logic             err_o
);
  logic [15:0] low_cnt, hi_cnt, sh_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
      sh_cnt  <= '0;
    end else begin
      low_cnt <= conv_n_o ? 16'd0 : ((low_cnt != '1) ? low_cnt + 16'd1 : low_cnt);
      hi_cnt  <= !conv_n_o ? 16'd0 : ((hi_cnt != '1) ? hi_cnt + 16'd1 : hi_cnt);
      sh_cnt  <= !sclk_o ? 16'd0 : ((sh_cnt != '1) ? sh_cnt + 16'd1 : sh_cnt);
    end
  end

  a_r2_conv_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_n_o) |-> low_cnt == 16'(CONV_LOW_CYC));

  a_r3_clock_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> hi_cnt >= 16'(SCLK_GAP_CYC - CONV_LOW_CYC));

  a_r4_clock_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r9_error_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (conv_n_o && cs_n_o && !sclk_o));

  a_r11_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> sh_cnt == 16'(div_i) + 16'd1);
endmodule

bind adc_split_reader adc_split_reader_chk #(
  .DIV_W       (DIV_W),
  .CONV_LOW_CYC(CONV_LOW_CYC),
  .SCLK_GAP_CYC(SCLK_GAP_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_i     (div_i),
  .conv_n_o  (conv_n_o),
  .cs_n_o    (cs_n_o),
  .sclk_o    (sclk_o),
  .rd_valid_o(rd_valid_o),
  .err_o     (err_o)
);

// File: tb/sim_adc_split_reader.sv
`timescale 1ns/1ps
module sim_adc_split_reader;
  localparam int CLK_NS  = 8;
  localparam int DIV     = 7;
  localparam int PER     = 700;
  localparam int TMO     = 600;
  localparam int CLOW    = 13;
  localparam int GAP     = 16;
  localparam int CONV_NS = 3200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] period_i = 16'(PER);
  logic [7:0]  div_i = 8'(DIV);
  logic        conv_n_o, cs_n_o, sclk_o, rd_valid_o, err_o;
  logic [11:0] rd_data_o;
  logic [3:0]  rd_tag_o;

  logic        m_busy = 1'b1;
  logic        m_dat = 1'b0;
  logic [11:0] m_sh = '0;
  bit          m_mute = 1'b0;
  bit          m_rose = 1'b0;
  int          m_nconv = 0, m_nword = 0, exp_r2 = 0;
  int          rises_conv = 0, rises_busy = 0;
  time         t_cfall = 0, t_srise = 0, t_sfall = 0;
  bit          skip_space = 1'b0;
  logic [11:0] exp_w [16];
  int          nvalid = 0, first_valid_nconv = -1, last_tag = -1;
  bit          prev_v = 1'b0;
  int          errs = 0, checks = 0;

  adc_split_reader #(.TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i), .div_i(div_i),
    .conv_n_o(conv_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_i(m_busy),
    .sdata_i(m_dat), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_tag_o(rd_tag_o), .err_o(err_o)
  );

  always #(CLK_NS/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] word_of(input int i);
    case (i % 8)
      0: return 12'h800;
      1: return 12'h7FF;
      2: return 12'h000;
      3: return 12'hFFF;
      4: return 12'hA5C;
      5: return 12'h3C3;
      6: return 12'h001;
      default: return 12'h5A0;
    endcase
  endfunction

  // converter model
  initial begin
    for (int i = 0; i < 16; i++) exp_w[i] = '0;
    forever begin
      @(negedge conv_n_o);
      if (m_nconv > 0 && !skip_space)
        chk(($time - t_cfall) == PER*CLK_NS, "R2", "start spacing ns", $time - t_cfall, PER*CLK_NS);
      skip_space = 1'b0;
      if (m_rose) chk(rises_busy == 8, "R5", "first burst pulses", rises_busy, 8);
      exp_r2 = m_rose ? 4 : 0;
      m_rose = 1'b0;
      t_cfall = $time;
      rises_conv = 0;
      m_nconv++;
      if (!m_mute) begin
        #40 m_busy = 1'b0;
        #(CONV_NS);
        chk(!sclk_o && ($time - t_sfall) >= 2000, "R4", "clock quiet ns before busy", $time - t_sfall, 2000);
        chk(rises_conv == exp_r2, "R5", "second burst pulses", rises_conv, exp_r2);
        if (!sclk_o || cs_n_o) begin
          m_sh = word_of(m_nword);
          exp_w[(m_nconv-1) % 16] = m_sh;
          m_nword++;
        end
        m_busy = 1'b1;
        m_rose = 1'b1;
        rises_busy = 0;
      end
    end
  end

  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      m_dat = m_sh[11];
      m_sh  = {m_sh[10:0], 1'b0};
    end
    if (rises_conv == 0 && !m_rose)
      chk(($time - t_cfall) >= GAP*CLK_NS, "R3", "first clock after convert ns", $time - t_cfall, GAP*CLK_NS);
    if (t_sfall != 0)
      chk(($time - t_sfall) >= (DIV+1)*CLK_NS, "R11", "low phase ns", $time - t_sfall, (DIV+1)*CLK_NS);
    rises_conv++;
    rises_busy++;
    t_srise = $time;
  end

  always @(negedge sclk_o) begin
    chk(($time - t_srise) == (DIV+1)*CLK_NS, "R11", "high phase ns", $time - t_srise, (DIV+1)*CLK_NS);
    t_sfall = $time;
  end

  always @(posedge conv_n_o)
    chk(($time - t_cfall) == CLOW*CLK_NS, "R2", "convert low ns", $time - t_cfall, CLOW*CLK_NS);

  always @(negedge clk_i) begin
    if (rd_valid_o) begin
      chk(!prev_v, "R6", "strobe width", 2, 1);
      nvalid++;
      if (first_valid_nconv < 0) first_valid_nconv = m_nconv;
      last_tag = int'(rd_tag_o);
      chk(rd_data_o == exp_w[rd_tag_o], "R6", "word", rd_data_o, exp_w[rd_tag_o]);
      chk(int'(rd_tag_o) == (m_nconv - 2) % 16, "R7", "tag", rd_tag_o, (m_nconv - 2) % 16);
      if (exp_w[rd_tag_o] == 12'h800)
        chk($signed(rd_data_o) == -2048, "R6", "signed value", $signed(rd_data_o), -2048);
    end
    prev_v = rd_valid_o;
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_valids(input int n, input string req);
    int c = 0;
    while (nvalid < n && c < 20000) begin
      @(negedge clk_i);
      c++;
    end
    chk(nvalid >= n, req, "valid count", nvalid, n);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    en_i   = 1'b0;
    wait_cycles(5);
    chk(conv_n_o && cs_n_o && !sclk_o && !rd_valid_o && !err_o, "R1", "outputs in reset",
        {conv_n_o, cs_n_o, sclk_o, rd_valid_o, err_o}, 5'b11000);
    rst_ni = 1'b1;
    wait_cycles(200);
    chk(conv_n_o && cs_n_o && !sclk_o && !rd_valid_o && !err_o, "R1", "outputs idle",
        {conv_n_o, cs_n_o, sclk_o, rd_valid_o, err_o}, 5'b11000);
    chk(m_nconv == 0, "R10", "convert while disabled", m_nconv, 0);
  endtask

  task automatic t_stream();
    en_i = 1'b1;
    wait_valids(6, "R6");
    chk(first_valid_nconv == 2, "R8", "convert count at first word", first_valid_nconv, 2);
    chk(!err_o, "R9", "no error in normal flow", err_o, 0);
  endtask

  task automatic t_pause();
    int n0;
    en_i = 1'b0;
    wait_cycles(1000);
    n0 = m_nconv;
    wait_cycles(2000);
    chk(m_nconv == n0, "R10", "converts while paused", m_nconv, n0);
    chk(conv_n_o && cs_n_o && !sclk_o, "R10", "idle lines while paused",
        {conv_n_o, cs_n_o, sclk_o}, 3'b110);
    skip_space = 1'b1;
    en_i = 1'b1;
    wait_valids(nvalid + 2, "R7");
  endtask

  task automatic t_timeout();
    int c = 0, nv0, b_idx;
    @(posedge m_busy);
    m_mute = 1'b1;
    while (!err_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    chk(err_o, "R9", "error flag", err_o, 1);
    chk(cs_n_o && !sclk_o, "R9", "lines idle on error", {cs_n_o, sclk_o}, 2'b10);
    chk(rises_conv == 4, "R9", "pulses in timed-out conversion", rises_conv, 4);
    nv0 = nvalid;
    m_mute = 1'b0;
    @(negedge conv_n_o);
    #1;
    chk(err_o, "R9", "error held until busy", err_o, 1);
    b_idx = m_nconv - 1;
    c = 0;
    while (err_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    chk(!err_o, "R9", "error cleared on busy", err_o, 0);
    chk(nvalid == nv0, "R8", "words after timeout", nvalid, nv0);
    wait_valids(nv0 + 1, "R8");
    chk(last_tag == b_idx % 16, "R8", "first tag after timeout", last_tag, b_idx % 16);
    wait_valids(nv0 + 3, "R6");
  endtask

  initial begin
    t_reset();
    t_stream();
    t_pause();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(100000 * CLK_NS);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule